// File: doc/BRIEF.md
# Software-Refilled Two-Level Translation Buffer

This block turns virtual page numbers into physical page numbers for an instruction-fetch requester and a data requester. Each side has its own small first-level store of translations. This store is searched associatively in the cycle a request arrives. Behind both sides sits one larger second-level store. The second level is consulted only for a request that missed its first level. It serves one requester per cycle, and a data request is served before an instruction request.

The block never walks page tables. When a translation is absent, a per-level exception pulse reports the page that failed. A first-level miss is followed automatically by a second-level probe. A second-level miss ends the request and leaves refill to software. Software installs a translation by writing a 64-bit page-table entry into an explicit slot of a chosen store, in the same way it would write a register file. It can read any slot back. A second-level hit copies the entry into the requesting side's first level at a rotating victim slot. A flush input clears all entries, or only the non-global entries of one address-space identifier, in one cycle.

Top module: `xt_tlb2`

## Requirements
- R1: After reset every slot of all three stores reads back as an all-zero entry, and the busy, done, hit, perm_fault, l1_miss and l2_miss outputs of both sides are low.
- R2: A slot matches only when its valid bit is set, its stored page number equals the request page number, and either its global bit is set or its stored ASID equals the request ASID.
- R3: A request accepted while its side is idle and that hits the first level gives done together with hit (or perm_fault) and the entry's physical page number exactly one clock edge after the request is sampled.
- R4: A first-level miss raises l1_miss for one cycle, one edge after the request, with fault_vpn equal to the requested page. busy is high in that same cycle. The second level is searched only for such a pending request.
- R5: A second-level hit completes one edge later than a first-level hit (two edges after the request). The entry is copied into that side's first level at a round-robin victim slot that starts at 0 after reset and advances by one per refill.
- R6: A second-level miss completes two edges after the request with done and l2_miss high, hit low, and fault_vpn equal to the requested page.
- R7: On a hit, the access is checked against the entry's permissions. A fetch needs X, a data load needs R and a data store needs W. A violation gives done with perm_fault high and hit low.
- R8: sw_we writes the entry built from sw_vpn, sw_asid and sw_pte into slot sw_idx of the store picked by sw_sel (0 = fetch-side first level, 1 = data-side first level, 2 = second level, 3 = nothing). The PTE layout has V at bit 0, R at bit 1, W at bit 2, X at bit 3, G at bit 5 and the page number at bits 53:10. sw_rd_sel and sw_rd_idx read a slot back in the same layout, with all other bits zero.
- R9: flush_all clears the valid bit of every slot in all three stores at the next edge.
- R10: flush_asid_en clears only those slots that are non-global and whose ASID equals flush_asid. Global slots and slots of other ASIDs keep translating.
- R11: When both sides wait for the second level in the same cycle, the data request completes first and the fetch request completes one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_req | input | 1 | Fetch-side lookup request (sampled when i_busy is low) |
| i_vpn | input | 36 | Fetch-side virtual page number |
| i_asid | input | 16 | Fetch-side address-space identifier |
| i_busy | output | 1 | Fetch side waits for the second level |
| i_done | output | 1 | Fetch-side result valid for one cycle |
| i_hit | output | 1 | Fetch translation succeeded |
| i_perm_fault | output | 1 | Fetch hit a slot without X permission |
| i_ppn | output | 44 | Fetch-side physical page number |
| i_l1_miss | output | 1 | Fetch-side first-level miss exception pulse |
| i_l2_miss | output | 1 | Fetch-side second-level miss exception pulse |
| i_fault_vpn | output | 36 | Page reported with the last fetch-side miss |
| d_req | input | 1 | Data-side lookup request (sampled when d_busy is low) |
| d_vpn | input | 36 | Data-side virtual page number |
| d_asid | input | 16 | Data-side address-space identifier |
| d_store | input | 1 | 1 = store access, 0 = load access |
| d_busy | output | 1 | Data side waits for the second level |
| d_done | output | 1 | Data-side result valid for one cycle |
| d_hit | output | 1 | Data translation succeeded |
| d_perm_fault | output | 1 | Data access violated R or W permission |
| d_ppn | output | 44 | Data-side physical page number |
| d_l1_miss | output | 1 | Data-side first-level miss exception pulse |
| d_l2_miss | output | 1 | Data-side second-level miss exception pulse |
| d_fault_vpn | output | 36 | Page reported with the last data-side miss |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate non-global slots of flush_asid |
| flush_asid | input | 16 | ASID selected for a targeted flush |
| sw_we | input | 1 | Software slot write strobe |
| sw_sel | input | 2 | Target store for write |
| sw_idx | input | 5 | Target slot for write |
| sw_vpn | input | 36 | Page number written |
| sw_asid | input | 16 | ASID written |
| sw_pte | input | 64 | Page-table entry written |
| sw_rd_sel | input | 2 | Store selected for read-back |
| sw_rd_idx | input | 5 | Slot selected for read-back |
| sw_rd_pte | output | 64 | Read-back page-table entry |
| sw_rd_vpn | output | 36 | Read-back page number |
| sw_rd_asid | output | 16 | Read-back ASID |

## Verification
The hardest case to reach is two requests contending for the second level. Both sides must miss their first levels on the same edge, so that both are pending together. The stimulus first installs one page only in the second level. It then raises fetch and data requests for that page in the same cycle. Completion is expected two edges later on the data side and three edges later on the fetch side. The same step fills both first levels by refill, which lets the bench check, by read-back, that each side's victim pointer has advanced on its own before the targeted flush is applied.

// File: rtl/xt_pkg.sv
package xt_pkg;
    localparam int VPN_W  = 36;
    localparam int PPN_W  = 44;
    localparam int ASID_W = 16;
    localparam int PTE_W  = 64;

    typedef struct packed {
        logic              v;
        logic              g;
        logic              r;
        logic              w;
        logic              x;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
    } xt_ent_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } xt_acc_e;

    function automatic logic xt_allowed(xt_ent_t e, xt_acc_e a);
        case (a)
            ACC_LOAD:  return e.r;
            ACC_STORE: return e.w;
            ACC_FETCH: return e.x;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic xt_ent_t xt_from_pte(logic [VPN_W-1:0] vpn,
                                            logic [ASID_W-1:0] asid,
                                            logic [PTE_W-1:0] pte);
        xt_ent_t e;
        e.v    = pte[0];
        e.r    = pte[1];
        e.w    = pte[2];
        e.x    = pte[3];
        e.g    = pte[5];
        e.ppn  = pte[10 +: PPN_W];
        e.vpn  = vpn;
        e.asid = asid;
        return e;
    endfunction

    function automatic logic [PTE_W-1:0] xt_to_pte(xt_ent_t e);
        logic [PTE_W-1:0] p;
        p = '0;
        p[0] = e.v;
        p[1] = e.r;
        p[2] = e.w;
        p[3] = e.x;
        p[5] = e.g;
        p[10 +: PPN_W] = e.ppn;
        return p;
    endfunction
endpackage

// File: rtl/xt_array.sv
module xt_array
    import xt_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_en,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output xt_ent_t           lk_ent,
    input  logic              fl_all,
    input  logic              fl_asid_en,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              wa_en,
    input  logic [IW-1:0]     wa_idx,
    input  xt_ent_t           wa_ent,
    input  logic              wb_en,
    input  logic [IW-1:0]     wb_idx,
    input  xt_ent_t           wb_ent,
    input  logic [IW-1:0]     rd_idx,
    output xt_ent_t           rd_ent
);
    typedef struct packed {
        xt_ent_t [N-1:0] ent;
    } st_t;

    st_t q, d;
    logic [N-1:0] mvec;

    // associative compare, gated so an idle store does not toggle
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign mvec[g] = lk_en && q.ent[g].v && (q.ent[g].vpn == lk_vpn)
                         && (q.ent[g].g || (q.ent[g].asid == lk_asid));
    end

    always_comb begin
        lk_hit = |mvec;
        lk_ent = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (mvec[k]) lk_ent = q.ent[k];
        end
        rd_ent = q.ent[rd_idx];
    end

    // flush first, then refill, then software write (last one wins)
    always_comb begin
        d = q;
        for (int k = 0; k < N; k++) begin
            if (fl_all || (fl_asid_en && !q.ent[k].g && (q.ent[k].asid == fl_asid)))
                d.ent[k].v = 1'b0;
        end
        if (wa_en) d.ent[wa_idx] = wa_ent;
        if (wb_en) d.ent[wb_idx] = wb_ent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/xt_port.sv
module xt_port
    import xt_pkg::*;
#(
    parameter int L1_N     = 8,
    parameter bit IS_FETCH = 1'b0,
    localparam int IW = (L1_N > 1) ? $clog2(L1_N) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    input  logic              store,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              perm_fault,
    output logic [PPN_W-1:0]  ppn,
    output logic              l1_miss,
    output logic              l2_miss,
    output logic [VPN_W-1:0]  fault_vpn,
    output logic [VPN_W-1:0]  key_vpn,
    output logic [ASID_W-1:0] key_asid,
    input  logic              gnt,
    input  logic              l2_hit,
    input  xt_ent_t           l2_ent,
    input  logic              fl_all,
    input  logic              fl_asid_en,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              sw_we,
    input  logic [IW-1:0]     sw_idx,
    input  xt_ent_t           sw_ent,
    input  logic [IW-1:0]     rd_idx,
    output xt_ent_t           rd_ent
);
    typedef struct packed {
        logic              pend;
        xt_acc_e           acc;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [IW-1:0]     rr;
        logic              done;
        logic              hit;
        logic              pfault;
        logic              l1m;
        logic              l2m;
        logic [PPN_W-1:0]  ppn;
        logic [VPN_W-1:0]  fvpn;
    } st_t;

    st_t     q, d;
    logic    l1_hit;
    xt_ent_t l1_ent;
    xt_acc_e acc_now;
    logic    refill;

    xt_array #(.N(L1_N)) u_l1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_en      (req && !q.pend),
        .lk_vpn     (vpn),
        .lk_asid    (asid),
        .lk_hit     (l1_hit),
        .lk_ent     (l1_ent),
        .fl_all     (fl_all),
        .fl_asid_en (fl_asid_en),
        .fl_asid    (fl_asid),
        .wa_en      (refill),
        .wa_idx     (q.rr),
        .wa_ent     (l2_ent),
        .wb_en      (sw_we),
        .wb_idx     (sw_idx),
        .wb_ent     (sw_ent),
        .rd_idx     (rd_idx),
        .rd_ent     (rd_ent)
    );

    always_comb begin
        acc_now = IS_FETCH ? ACC_FETCH : (store ? ACC_STORE : ACC_LOAD);
        d        = q;
        d.done   = 1'b0;
        d.hit    = 1'b0;
        d.pfault = 1'b0;
        d.l1m    = 1'b0;
        d.l2m    = 1'b0;
        refill   = 1'b0;
        if (q.pend) begin
            if (gnt) begin
                d.pend = 1'b0;
                d.done = 1'b1;
                if (l2_hit) begin
                    refill = 1'b1;
                    d.rr   = (q.rr == IW'(L1_N - 1)) ? '0 : q.rr + 1'b1;
                    d.ppn  = l2_ent.ppn;
                    if (xt_allowed(l2_ent, q.acc)) d.hit = 1'b1;
                    else                           d.pfault = 1'b1;
                end else begin
                    d.l2m  = 1'b1;
                    d.fvpn = q.vpn;
                end
            end
        end else if (req) begin
            if (l1_hit) begin
                d.done = 1'b1;
                d.ppn  = l1_ent.ppn;
                if (xt_allowed(l1_ent, acc_now)) d.hit = 1'b1;
                else                             d.pfault = 1'b1;
            end else begin
                d.pend = 1'b1;
                d.l1m  = 1'b1;
                d.fvpn = vpn;
                d.vpn  = vpn;
                d.asid = asid;
                d.acc  = acc_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy       = q.pend;
    assign done       = q.done;
    assign hit        = q.hit;
    assign perm_fault = q.pfault;
    assign ppn        = q.ppn;
    assign l1_miss    = q.l1m;
    assign l2_miss    = q.l2m;
    assign fault_vpn  = q.fvpn;
    assign key_vpn    = q.vpn;
    assign key_asid   = q.asid;
endmodule

// File: rtl/xt_tlb2.sv
module xt_tlb2
    import xt_pkg::*;
#(
    parameter int L1_N = 8,
    parameter int L2_N = 32,
    localparam int I1W = (L1_N > 1) ? $clog2(L1_N) : 1,
    localparam int I2W = (L2_N > 1) ? $clog2(L2_N) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_req,
    input  logic [VPN_W-1:0]  i_vpn,
    input  logic [ASID_W-1:0] i_asid,
    output logic              i_busy,
    output logic              i_done,
    output logic              i_hit,
    output logic              i_perm_fault,
    output logic [PPN_W-1:0]  i_ppn,
    output logic              i_l1_miss,
    output logic              i_l2_miss,
    output logic [VPN_W-1:0]  i_fault_vpn,
    input  logic              d_req,
    input  logic [VPN_W-1:0]  d_vpn,
    input  logic [ASID_W-1:0] d_asid,
    input  logic              d_store,
    output logic              d_busy,
    output logic              d_done,
    output logic              d_hit,
    output logic              d_perm_fault,
    output logic [PPN_W-1:0]  d_ppn,
    output logic              d_l1_miss,
    output logic              d_l2_miss,
    output logic [VPN_W-1:0]  d_fault_vpn,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              sw_we,
    input  logic [1:0]        sw_sel,
    input  logic [I2W-1:0]    sw_idx,
    input  logic [VPN_W-1:0]  sw_vpn,
    input  logic [ASID_W-1:0] sw_asid,
    input  logic [PTE_W-1:0]  sw_pte,
    input  logic [1:0]        sw_rd_sel,
    input  logic [I2W-1:0]    sw_rd_idx,
    output logic [PTE_W-1:0]  sw_rd_pte,
    output logic [VPN_W-1:0]  sw_rd_vpn,
    output logic [ASID_W-1:0] sw_rd_asid
);
    xt_ent_t           sw_ent, l2_ent, rd_i, rd_d, rd_2, rd_sel_ent;
    logic              l2_hit, i_gnt, d_gnt;
    logic [VPN_W-1:0]  i_kv, d_kv, l2_kv;
    logic [ASID_W-1:0] i_ka, d_ka, l2_ka;

    assign sw_ent = xt_from_pte(sw_vpn, sw_asid, sw_pte);

    // shared second level: data side served first
    always_comb begin
        d_gnt = d_busy;
        i_gnt = i_busy && !d_busy;
        l2_kv = d_gnt ? d_kv : i_kv;
        l2_ka = d_gnt ? d_ka : i_ka;
    end

    xt_port #(.L1_N(L1_N), .IS_FETCH(1'b1)) u_ifetch (
        .clk(clk), .rst_n(rst_n), .req(i_req), .vpn(i_vpn), .asid(i_asid), .store(1'b0),
        .busy(i_busy), .done(i_done), .hit(i_hit), .perm_fault(i_perm_fault), .ppn(i_ppn),
        .l1_miss(i_l1_miss), .l2_miss(i_l2_miss), .fault_vpn(i_fault_vpn),
        .key_vpn(i_kv), .key_asid(i_ka), .gnt(i_gnt), .l2_hit(l2_hit), .l2_ent(l2_ent),
        .fl_all(flush_all), .fl_asid_en(flush_asid_en), .fl_asid(flush_asid),
        .sw_we(sw_we && (sw_sel == 2'd0)), .sw_idx(sw_idx[I1W-1:0]), .sw_ent(sw_ent),
        .rd_idx(sw_rd_idx[I1W-1:0]), .rd_ent(rd_i)
    );

    xt_port #(.L1_N(L1_N), .IS_FETCH(1'b0)) u_data (
        .clk(clk), .rst_n(rst_n), .req(d_req), .vpn(d_vpn), .asid(d_asid), .store(d_store),
        .busy(d_busy), .done(d_done), .hit(d_hit), .perm_fault(d_perm_fault), .ppn(d_ppn),
        .l1_miss(d_l1_miss), .l2_miss(d_l2_miss), .fault_vpn(d_fault_vpn),
        .key_vpn(d_kv), .key_asid(d_ka), .gnt(d_gnt), .l2_hit(l2_hit), .l2_ent(l2_ent),
        .fl_all(flush_all), .fl_asid_en(flush_asid_en), .fl_asid(flush_asid),
        .sw_we(sw_we && (sw_sel == 2'd1)), .sw_idx(sw_idx[I1W-1:0]), .sw_ent(sw_ent),
        .rd_idx(sw_rd_idx[I1W-1:0]), .rd_ent(rd_d)
    );

    xt_array #(.N(L2_N)) u_l2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_en      (i_busy || d_busy),
        .lk_vpn     (l2_kv),
        .lk_asid    (l2_ka),
        .lk_hit     (l2_hit),
        .lk_ent     (l2_ent),
        .fl_all     (flush_all),
        .fl_asid_en (flush_asid_en),
        .fl_asid    (flush_asid),
        .wa_en      (1'b0),
        .wa_idx     ('0),
        .wa_ent     ('0),
        .wb_en      (sw_we && (sw_sel == 2'd2)),
        .wb_idx     (sw_idx),
        .wb_ent     (sw_ent),
        .rd_idx     (sw_rd_idx),
        .rd_ent     (rd_2)
    );

    always_comb begin
        case (sw_rd_sel)
            2'd0:    rd_sel_ent = rd_i;
            2'd1:    rd_sel_ent = rd_d;
            2'd2:    rd_sel_ent = rd_2;
            default: rd_sel_ent = '0;
        endcase
        sw_rd_pte  = xt_to_pte(rd_sel_ent);
        sw_rd_vpn  = rd_sel_ent.vpn;
        sw_rd_asid = rd_sel_ent.asid;
    end
endmodule

// File: rtl/xt_chk.sv
module xt_chk (
    input logic clk,
    input logic rst_n,
    input logic i_busy,
    input logic i_done,
    input logic i_hit,
    input logic i_perm_fault,
    input logic i_l1_miss,
    input logic i_l2_miss,
    input logic d_busy,
    input logic d_done,
    input logic d_hit,
    input logic d_perm_fault,
    input logic d_l1_miss,
    input logic d_l2_miss
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!i_done && !d_done && !i_busy && !d_busy));

    p_result_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hit || d_perm_fault || i_hit || i_perm_fault) |-> ((d_done || !(d_hit || d_perm_fault))
                                                             && (i_done || !(i_hit || i_perm_fault))));

    p_l1miss_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_l1_miss || i_l1_miss) |-> ((!d_l1_miss || (d_busy && !d_done))
                                      && (!i_l1_miss || (i_busy && !i_done))));

    p_pending_ends_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(d_busy) |-> d_done);

    p_l2miss_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        d_l2_miss |-> (d_done && !d_hit && !d_perm_fault));

    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_hit && d_perm_fault) && !(i_hit && i_perm_fault));

    p_data_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (i_busy && d_busy) |=> (d_done && !d_busy && i_busy));
endmodule

bind xt_tlb2 xt_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .i_busy(i_busy), .i_done(i_done), .i_hit(i_hit), .i_perm_fault(i_perm_fault),
    .i_l1_miss(i_l1_miss), .i_l2_miss(i_l2_miss),
    .d_busy(d_busy), .d_done(d_done), .d_hit(d_hit), .d_perm_fault(d_perm_fault),
    .d_l1_miss(d_l1_miss), .d_l2_miss(d_l2_miss)
);

// File: tb/xt_tlb2_tb.sv
`timescale 1ns/1ps
module xt_tlb2_tb;
    import xt_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              i_req = 0, d_req = 0, d_store = 0;
    logic [VPN_W-1:0]  i_vpn = '0, d_vpn = '0;
    logic [ASID_W-1:0] i_asid = '0, d_asid = '0;
    logic              i_busy, i_done, i_hit, i_perm_fault, i_l1_miss, i_l2_miss;
    logic              d_busy, d_done, d_hit, d_perm_fault, d_l1_miss, d_l2_miss;
    logic [PPN_W-1:0]  i_ppn, d_ppn;
    logic [VPN_W-1:0]  i_fault_vpn, d_fault_vpn;
    logic              flush_all = 0, flush_asid_en = 0;
    logic [ASID_W-1:0] flush_asid = '0;
    logic              sw_we = 0;
    logic [1:0]        sw_sel = '0, sw_rd_sel = '0;
    logic [4:0]        sw_idx = '0, sw_rd_idx = '0;
    logic [VPN_W-1:0]  sw_vpn = '0;
    logic [ASID_W-1:0] sw_asid = '0;
    logic [PTE_W-1:0]  sw_pte = '0;
    logic [PTE_W-1:0]  sw_rd_pte;
    logic [VPN_W-1:0]  sw_rd_vpn;
    logic [ASID_W-1:0] sw_rd_asid;

    xt_tlb2 u_dut (.*);

    int n_chk = 0, n_err = 0, cyc = 0;
    bit ended = 0;

    typedef struct {
        int               due;
        bit               hit;
        bit               pf;
        bit               l2m;
        logic [PPN_W-1:0] ppn;
        logic [VPN_W-1:0] fvpn;
        string            tag;
    } exp_t;
    exp_t qi[$];
    exp_t qd[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_pte(logic [PPN_W-1:0] p, logic [7:0] fl);
        return {10'b0, p, 2'b00, fl};
    endfunction

    // monitor: pops expected results as the design reports completion
    task automatic cmp(exp_t e, bit h, bit pf, bit l2m, logic [PPN_W-1:0] p, logic [VPN_W-1:0] fv);
        chk(cyc == e.due, e.tag, "completion cycle", 64'(cyc), 64'(e.due));
        chk(h == e.hit, e.tag, "hit", 64'(h), 64'(e.hit));
        chk(pf == e.pf, e.tag, "perm_fault", 64'(pf), 64'(e.pf));
        chk(l2m == e.l2m, e.tag, "l2_miss", 64'(l2m), 64'(e.l2m));
        if (e.hit || e.pf) chk(p == e.ppn, e.tag, "ppn", 64'(p), 64'(e.ppn));
        if (e.l2m) chk(fv == e.fvpn, e.tag, "fault_vpn", 64'(fv), 64'(e.fvpn));
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (d_done) begin
                if (qd.size() == 0) chk(1'b0, "R3", "unexpected data done", 64'd1, 64'd0);
                else cmp(qd.pop_front(), d_hit, d_perm_fault, d_l2_miss, d_ppn, d_fault_vpn);
            end
            if (i_done) begin
                if (qi.size() == 0) chk(1'b0, "R3", "unexpected fetch done", 64'd1, 64'd0);
                else cmp(qi.pop_front(), i_hit, i_perm_fault, i_l2_miss, i_ppn, i_fault_vpn);
            end
        end
    end

    task automatic sw_write(input logic [1:0] sel, input int idx, input logic [VPN_W-1:0] v,
                            input logic [ASID_W-1:0] a, input logic [63:0] pte);
        @(negedge clk);
        sw_we = 1; sw_sel = sel; sw_idx = 5'(idx); sw_vpn = v; sw_asid = a; sw_pte = pte;
        @(negedge clk);
        sw_we = 0;
    endtask

    task automatic rd_check(input logic [1:0] sel, input int idx, input logic [VPN_W-1:0] v,
                            input logic [63:0] pte, input string rq);
        @(negedge clk);
        sw_rd_sel = sel; sw_rd_idx = 5'(idx);
        #1;
        chk(sw_rd_vpn == v, rq, "readback vpn", 64'(sw_rd_vpn), 64'(v));
        chk(sw_rd_pte == pte, rq, "readback pte", sw_rd_pte, pte);
    endtask

    // driver: one lookup on one side, expectation pushed to the scoreboard
    task automatic lookup(input bit side_d, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                          input bit st, input bit e_l1m, input bit e_hit, input bit e_pf,
                          input bit e_l2m, input logic [PPN_W-1:0] e_ppn, input string rq);
        exp_t e;
        @(negedge clk);
        e.due = cyc + (e_l1m ? 2 : 1);
        e.hit = e_hit; e.pf = e_pf; e.l2m = e_l2m; e.ppn = e_ppn; e.fvpn = v; e.tag = rq;
        if (side_d) begin
            d_req = 1; d_vpn = v; d_asid = a; d_store = st; qd.push_back(e);
        end else begin
            i_req = 1; i_vpn = v; i_asid = a; qi.push_back(e);
        end
        @(negedge clk);
        d_req = 0; i_req = 0;
        if (side_d) begin
            chk(d_l1_miss == e_l1m, "R4", "data l1_miss", 64'(d_l1_miss), 64'(e_l1m));
            if (e_l1m) chk(d_fault_vpn == v, "R4", "data fault_vpn", 64'(d_fault_vpn), 64'(v));
        end else begin
            chk(i_l1_miss == e_l1m, "R4", "fetch l1_miss", 64'(i_l1_miss), 64'(e_l1m));
            if (e_l1m) chk(i_fault_vpn == v, "R4", "fetch fault_vpn", 64'(i_fault_vpn), 64'(v));
        end
        while (i_busy || d_busy) @(negedge clk);
    endtask

    task automatic flush(input bit all, input logic [ASID_W-1:0] a);
        @(negedge clk);
        flush_all = all; flush_asid_en = !all; flush_asid = a;
        @(negedge clk);
        flush_all = 0; flush_asid_en = 0;
    endtask

    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08, FG = 8'h20;
    localparam logic [VPN_W-1:0] VA = 36'h0_0000_1A00, VB = 36'h0_0000_2B00,
                                 VC = 36'h0_0000_3C00, VE = 36'h0_0000_4E00,
                                 VF = 36'h0_0000_5F00;
    localparam logic [PPN_W-1:0] P1 = 44'h111, P2 = 44'h222, P3 = 44'h333,
                                 P4 = 44'h444, P5 = 44'h555;

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        exp_t ei, ed;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!(i_busy || d_busy || i_done || d_done || i_hit || d_hit || i_perm_fault ||
              d_perm_fault || i_l1_miss || d_l1_miss || i_l2_miss || d_l2_miss),
            "R1", "outputs idle in reset", 64'(d_done), 64'd0);
        rst_n = 1;
        rd_check(2'd2, 0, '0, '0, "R1");
        rd_check(2'd1, 0, '0, '0, "R1");
        rd_check(2'd0, 7, '0, '0, "R1");

        // R6: empty stores miss at both levels
        lookup(1, VA, 16'd5, 0, 1, 0, 0, 1, '0, "R6");

        // R8 write into second level, R5 hit there with refill
        sw_write(2'd2, 3, VA, 16'd5, mk_pte(P1, FV | FR | FW));
        rd_check(2'd2, 3, VA, mk_pte(P1, FV | FR | FW), "R8");
        lookup(1, VA, 16'd5, 0, 1, 1, 0, 0, P1, "R5");
        rd_check(2'd1, 0, VA, mk_pte(P1, FV | FR | FW), "R5");
        lookup(1, VA, 16'd5, 1, 0, 1, 0, 0, P1, "R3");

        // R2: ASID mismatch misses; global ignores ASID
        lookup(1, VA, 16'd6, 0, 1, 0, 0, 1, '0, "R2");
        sw_write(2'd1, 5, VB, 16'd1, mk_pte(P2, FV | FR | FG));
        lookup(1, VB, 16'd9, 0, 0, 1, 0, 0, P2, "R2");
        // R2: valid bit clear never matches
        sw_write(2'd1, 6, VE, 16'd1, mk_pte(P5, FR | FW));
        lookup(1, VE, 16'd1, 0, 1, 0, 0, 1, '0, "R2");

        // R7: permissions
        lookup(1, VB, 16'd9, 1, 0, 0, 1, 0, P2, "R7");
        sw_write(2'd0, 2, VC, 16'd2, mk_pte(P3, FV | FX));
        lookup(0, VC, 16'd2, 0, 0, 1, 0, 0, P3, "R3");
        sw_write(2'd0, 3, VE, 16'd2, mk_pte(P5, FV | FR));
        lookup(0, VE, 16'd2, 0, 0, 0, 1, 0, P5, "R7");

        // R11: both sides contend for the second level
        sw_write(2'd2, 7, VF, 16'd2, mk_pte(P4, FV | FR | FW | FX));
        @(negedge clk);
        ed.due = cyc + 2; ed.hit = 1; ed.pf = 0; ed.l2m = 0; ed.ppn = P4; ed.fvpn = VF; ed.tag = "R11";
        ei = ed; ei.due = cyc + 3;
        qd.push_back(ed); qi.push_back(ei);
        d_req = 1; d_vpn = VF; d_asid = 16'd2; d_store = 0;
        i_req = 1; i_vpn = VF; i_asid = 16'd2;
        @(negedge clk);
        d_req = 0; i_req = 0;
        chk(d_l1_miss && i_l1_miss, "R11", "both l1_miss", 64'({d_l1_miss, i_l1_miss}), 64'd3);
        while (i_busy || d_busy) @(negedge clk);
        // R5: victim pointers advanced per side
        rd_check(2'd1, 1, VF, mk_pte(P4, FV | FR | FW | FX), "R5");
        rd_check(2'd0, 0, VF, mk_pte(P4, FV | FR | FW | FX), "R5");
        lookup(0, VF, 16'd2, 0, 0, 1, 0, 0, P4, "R5");

        // R10: ASID flush spares global and other ASIDs
        flush(0, 16'd2);
        lookup(0, VF, 16'd2, 0, 1, 0, 0, 1, '0, "R10");
        lookup(0, VC, 16'd2, 0, 1, 0, 0, 1, '0, "R10");
        lookup(1, VA, 16'd5, 0, 0, 1, 0, 0, P1, "R10");
        lookup(1, VB, 16'd9, 0, 0, 1, 0, 0, P2, "R10");

        // R9: full flush
        flush(1, '0);
        lookup(1, VB, 16'd9, 0, 1, 0, 0, 1, '0, "R9");
        lookup(1, VA, 16'd5, 0, 1, 0, 0, 1, '0, "R9");
        rd_check(2'd2, 3, VA, mk_pte(P1, FR | FW), "R9");

        // R8: select 3 writes nothing
        sw_write(2'd3, 4, VC, 16'd7, mk_pte(P3, FV | FR));
        rd_check(2'd2, 4, '0, '0, "R8");
        rd_check(2'd1, 4, '0, '0, "R8");

        repeat (3) @(negedge clk);
        chk(qi.size() == 0 && qd.size() == 0, "R3", "all results reported",
            64'(qi.size() + qd.size()), 64'd0);
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule